// File: doc/BRIEF.md
# Receiver-Detect and Reverse Loopback Controller

This block sits on the PHY side of a PIPE-style link. One command input, `det_lpbk_cmd`, means different things depending on the link power state. In P1 a rising edge on it starts a receiver-detect sequence. The sequence runs on its own fixed detect clock, `clk_fixed`, while the rest of the block runs on the parallel clock `pclk`. The block keeps the transmitter in electrical idle, raises a detect request towards the analog front end, and waits for a result or a programmable timeout. It then reports the outcome to the MAC as a single-cycle PHY status pulse together with a three-bit receiver status code.

In P0 at the first-generation rate, the same command switches on reverse parallel loopback. The aligned and rate-matched receive data is then driven onto the serializer input in place of user transmit data, and it still reaches the user receive port. The analog step generation and time-constant measurement are not part of this block. The front end is represented by a request/result handshake in the `clk_fixed` domain.

Launcher FSM (pclk): `L_IDLE` goes to `L_BUSY` on a command rising edge in P1, which toggles the start flag. `L_BUSY` goes to `L_IDLE` when the completion toggle arrives. Detect FSM (clk_fixed): `D_IDLE` goes to `D_REQ` on a start toggle. `D_REQ` goes to `D_REPORT` on `det_done` or on timeout. `D_REPORT` goes to `D_IDLE` and flips the completion toggle. Loopback FSM (pclk): `LB_OFF` goes to `LB_ON` when the command is high in P0 at Gen1. `LB_ON` goes to `LB_OFF` as soon as any of those conditions drops.

Top module: `pipe_rdl_ctrl`

## Requirements
- R1: After reset, `phy_status` is 0, `rx_status` is 3'b000, `det_req` is 0, `loopback_active` is 0, and `tx_ser_data` equals `tx_user_data`.
- R2: A 0-to-1 transition of `det_lpbk_cmd` while `power_state` is 2'b10 (P1) starts one detect sequence. This is seen as one rising edge of `det_req` in the `clk_fixed` domain.
- R3: Whenever `power_state` is 2'b10 (P1), `tx_elecidle` is 1, including throughout a detect sequence.
- R4: On detect completion, `phy_status` is high for exactly one `pclk` cycle. In that cycle `rx_status` is 3'b011 if a receiver was found and 3'b000 if not. At all other times `rx_status` is 3'b000.
- R5: `det_req` stays high for at most `timeout_limit` `clk_fixed` cycles (a limit of 0 behaves as 1). If `det_done` has not arrived by then, the result is reported as no receiver (3'b000).
- R6: Holding `det_lpbk_cmd` high does not start another detect. Command edges that arrive while a detect is in progress are ignored.
- R7: With `power_state` 2'b00 (P0), `rate_gen2` 0 and `det_lpbk_cmd` high, the block enters loopback on the next `pclk` edge. `loopback_active` is then 1, `tx_ser_data` equals `rx_align_data`, and no detect is started.
- R8: With `rate_gen2` 1 the loopback request is ignored. `tx_ser_data` keeps following `tx_user_data` and `loopback_active` stays 0.
- R9: `rx_user_data` always equals `rx_align_data`, both in and out of loopback.
- R10: If `det_lpbk_cmd` falls, `power_state` leaves P0, or `rate_gen2` rises, loopback ends at the next `pclk` edge and `tx_ser_data` returns to `tx_user_data`.
- R11: Asserting `det_lpbk_cmd` in P0s (2'b01) or P2 (2'b11) has no effect: no detect request, no status pulse, and no loopback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Parallel datapath clock |
| clk_fixed | input | 1 | Fixed 125 MHz detect clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| power_state | input | 2 | Link power state: 00 P0, 01 P0s, 10 P1, 11 P2 |
| rate_gen2 | input | 1 | 0 = first-generation rate, 1 = higher rate |
| det_lpbk_cmd | input | 1 | Combined detect / loopback command |
| timeout_limit | input | CW | Detect timeout in clk_fixed cycles |
| det_req | output | 1 | Detect request to analog front end (clk_fixed) |
| det_done | input | 1 | Front end result valid (clk_fixed) |
| det_found | input | 1 | Front end saw a receiver, valid with det_done |
| tx_user_data | input | DW | User transmit data |
| tx_user_elecidle | input | 1 | User electrical-idle request |
| rx_align_data | input | DW | Received data after alignment and rate matching |
| tx_ser_data | output | DW | Data to the transmit serializer |
| tx_elecidle | output | 1 | Electrical idle to transmit buffer |
| rx_user_data | output | DW | Received data to user side |
| phy_status | output | 1 | One-cycle completion pulse |
| rx_status | output | 3 | Receiver status code |
| loopback_active | output | 1 | Reverse loopback engaged |

## Verification
Detect is run with a responding front end that reports a receiver, one that reports none, and a silent front end that forces the timeout. These three runs separate the found code, the not-found code and the timeout path. The command is also held high past completion and toggled again mid-sequence, which separates level triggering from edge triggering. Loopback is exercised with changing data patterns to show the data source, and then torn down three ways: command drop, power-state change and rate change. The command is finally applied in P0s, P2 and at Gen2 to confirm that nothing reacts.

// File: rtl/pipe_rdl_pkg.sv
package pipe_rdl_pkg;

    typedef enum logic [1:0] {
        PS_P0  = 2'b00,
        PS_P0S = 2'b01,
        PS_P1  = 2'b10,
        PS_P2  = 2'b11
    } pstate_e;

    typedef enum logic {
        L_IDLE = 1'b0,
        L_BUSY = 1'b1
    } launch_st_e;

    typedef enum logic [1:0] {
        D_IDLE   = 2'b00,
        D_REQ    = 2'b01,
        D_REPORT = 2'b10
    } detect_st_e;

    typedef enum logic {
        LB_OFF = 1'b0,
        LB_ON  = 1'b1
    } lpbk_st_e;

    localparam logic [2:0] RXST_FOUND = 3'b011;
    localparam logic [2:0] RXST_NONE  = 3'b000;

endpackage

// File: rtl/rdl_sync.sv
module rdl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rdl_launch.sv
module rdl_launch
    import pipe_rdl_pkg::*;
(
    input  logic       pclk,
    input  logic       rst_n,
    input  logic       cmd,
    input  logic [1:0] power_state,
    input  logic       done_evt,
    output logic       start_tgl,
    output logic       busy
);
    launch_st_e state, state_nx;
    logic       cmd_q;
    logic       cmd_rise;
    logic       fire;

    assign cmd_rise = cmd & ~cmd_q;

    always_comb begin
        state_nx = state;
        fire     = 1'b0;
        unique case (state)
            L_IDLE: if (cmd_rise && power_state == PS_P1) begin
                state_nx = L_BUSY;
                fire     = 1'b1;
            end
            L_BUSY: if (done_evt) state_nx = L_IDLE;
            default: state_nx = L_IDLE;
        endcase
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            state <= L_IDLE;
            cmd_q <= 1'b0;
        end else begin
            state <= state_nx;
            cmd_q <= cmd;
        end
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n)    start_tgl <= 1'b0;
        else if (fire) start_tgl <= ~start_tgl;
    end

    assign busy = (state == L_BUSY);
endmodule

// File: rtl/rdl_detect.sv
module rdl_detect
    import pipe_rdl_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk_fixed,
    input  logic          rst_n,
    input  logic          start_s,
    input  logic [CW-1:0] timeout_limit,
    input  logic          det_done,
    input  logic          det_found,
    output logic          det_req,
    output logic          done_tgl,
    output logic          found_q
);
    localparam int XW = CW + 1;

    detect_st_e    state, state_nx;
    logic          start_q;
    logic          start_evt;
    logic [CW-1:0] cnt;
    logic          expired;
    logic          latch_res;
    logic          res_nx;

    assign start_evt = start_s ^ start_q;
    assign expired   = ({1'b0, cnt} + XW'(1)) >= {1'b0, timeout_limit};

    always_comb begin
        state_nx  = state;
        latch_res = 1'b0;
        res_nx    = 1'b0;
        unique case (state)
            D_IDLE: if (start_evt) state_nx = D_REQ;
            D_REQ: begin
                if (det_done) begin
                    state_nx  = D_REPORT;
                    latch_res = 1'b1;
                    res_nx    = det_found;
                end else if (expired) begin
                    state_nx  = D_REPORT;
                    latch_res = 1'b1;
                    res_nx    = 1'b0;
                end
            end
            D_REPORT: state_nx = D_IDLE;
            default:  state_nx = D_IDLE;
        endcase
    end

    always_ff @(posedge clk_fixed or negedge rst_n) begin
        if (!rst_n) begin
            state   <= D_IDLE;
            start_q <= 1'b0;
        end else begin
            state   <= state_nx;
            start_q <= start_s;
        end
    end

    always_ff @(posedge clk_fixed or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            found_q  <= 1'b0;
            done_tgl <= 1'b0;
        end else begin
            if (state == D_REQ) cnt <= cnt + CW'(1);
            else                cnt <= '0;
            if (latch_res)          found_q  <= res_nx;
            if (state == D_REPORT)  done_tgl <= ~done_tgl;
        end
    end

    assign det_req = (state == D_REQ);
endmodule

// File: rtl/rdl_report.sv
module rdl_report
    import pipe_rdl_pkg::*;
(
    input  logic       pclk,
    input  logic       rst_n,
    input  logic       done_s,
    input  logic       found_q,
    output logic       done_evt,
    output logic       phy_status,
    output logic [2:0] rx_status
);
    logic done_q;

    assign done_evt = done_s ^ done_q;

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            phy_status <= 1'b0;
            rx_status  <= RXST_NONE;
        end else begin
            done_q     <= done_s;
            phy_status <= done_evt;
            if (done_evt) rx_status <= found_q ? RXST_FOUND : RXST_NONE;
            else          rx_status <= RXST_NONE;
        end
    end
endmodule

// File: rtl/rdl_loopback.sv
module rdl_loopback
    import pipe_rdl_pkg::*;
(
    input  logic       pclk,
    input  logic       rst_n,
    input  logic       cmd,
    input  logic [1:0] power_state,
    input  logic       rate_gen2,
    output logic       active
);
    lpbk_st_e state, state_nx;
    logic     allowed;

    assign allowed = cmd && (power_state == PS_P0) && !rate_gen2;

    always_comb begin
        state_nx = state;
        unique case (state)
            LB_OFF:  if (allowed)  state_nx = LB_ON;
            LB_ON:   if (!allowed) state_nx = LB_OFF;
            default: state_nx = LB_OFF;
        endcase
    end

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) state <= LB_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        active = (state == LB_ON);
    end
endmodule

// File: rtl/pipe_rdl_ctrl.sv
module pipe_rdl_ctrl
    import pipe_rdl_pkg::*;
#(
    parameter int DW          = 16,
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          pclk,
    input  logic          clk_fixed,
    input  logic          rst_n,
    input  logic [1:0]    power_state,
    input  logic          rate_gen2,
    input  logic          det_lpbk_cmd,
    input  logic [CW-1:0] timeout_limit,
    output logic          det_req,
    input  logic          det_done,
    input  logic          det_found,
    input  logic [DW-1:0] tx_user_data,
    input  logic          tx_user_elecidle,
    input  logic [DW-1:0] rx_align_data,
    output logic [DW-1:0] tx_ser_data,
    output logic          tx_elecidle,
    output logic [DW-1:0] rx_user_data,
    output logic          phy_status,
    output logic [2:0]    rx_status,
    output logic          loopback_active
);
    logic start_tgl, start_s;
    logic done_tgl, done_s;
    logic done_evt;
    logic found_q;
    logic busy;

    rdl_launch u_launch (
        .pclk        (pclk),
        .rst_n       (rst_n),
        .cmd         (det_lpbk_cmd),
        .power_state (power_state),
        .done_evt    (done_evt),
        .start_tgl   (start_tgl),
        .busy        (busy)
    );

    rdl_sync #(.STAGES(SYNC_STAGES)) u_sync_start (
        .clk   (clk_fixed),
        .rst_n (rst_n),
        .d     (start_tgl),
        .q     (start_s)
    );

    rdl_detect #(.CW(CW)) u_detect (
        .clk_fixed     (clk_fixed),
        .rst_n         (rst_n),
        .start_s       (start_s),
        .timeout_limit (timeout_limit),
        .det_done      (det_done),
        .det_found     (det_found),
        .det_req       (det_req),
        .done_tgl      (done_tgl),
        .found_q       (found_q)
    );

    rdl_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
        .clk   (pclk),
        .rst_n (rst_n),
        .d     (done_tgl),
        .q     (done_s)
    );

    rdl_report u_report (
        .pclk       (pclk),
        .rst_n      (rst_n),
        .done_s     (done_s),
        .found_q    (found_q),
        .done_evt   (done_evt),
        .phy_status (phy_status),
        .rx_status  (rx_status)
    );

    rdl_loopback u_lpbk (
        .pclk        (pclk),
        .rst_n       (rst_n),
        .cmd         (det_lpbk_cmd),
        .power_state (power_state),
        .rate_gen2   (rate_gen2),
        .active      (loopback_active)
    );

    always_comb begin
        tx_ser_data  = loopback_active ? rx_align_data : tx_user_data;
        rx_user_data = rx_align_data;
        if (power_state == PS_P1)  tx_elecidle = 1'b1;
        else if (loopback_active)  tx_elecidle = 1'b0;
        else                       tx_elecidle = tx_user_elecidle;
    end

    logic unused_busy;
    assign unused_busy = busy;
endmodule

// File: rtl/pipe_rdl_checker.sv
module pipe_rdl_checker #(
    parameter int CW = 16
) (
    input logic          pclk,
    input logic          clk_fixed,
    input logic          rst_n,
    input logic [1:0]    power_state,
    input logic          rate_gen2,
    input logic          det_lpbk_cmd,
    input logic [CW-1:0] timeout_limit,
    input logic          det_req,
    input logic          tx_elecidle,
    input logic          phy_status,
    input logic [2:0]    rx_status,
    input logic          loopback_active
);
    logic [CW:0] req_run;
    logic [CW:0] limit_eff;

    assign limit_eff = (timeout_limit == '0) ? (CW+1)'(1) : {1'b0, timeout_limit};

    always_ff @(posedge clk_fixed or negedge rst_n) begin
        if (!rst_n)       req_run <= '0;
        else if (det_req) req_run <= req_run + (CW+1)'(1);
        else              req_run <= '0;
    end

    p_req_bound_r5: assert property (@(posedge clk_fixed) disable iff (!rst_n)
        det_req |-> (req_run < limit_eff));

    p_idle_in_p1_r3: assert property (@(posedge pclk) disable iff (!rst_n)
        (power_state == 2'b10) |-> tx_elecidle);

    p_status_pulse_r4: assert property (@(posedge pclk) disable iff (!rst_n)
        phy_status |=> !phy_status);

    p_status_code_r4: assert property (@(posedge pclk) disable iff (!rst_n)
        (rx_status != 3'b000) |-> (phy_status && rx_status == 3'b011));

    p_lpbk_gen1_r8: assert property (@(posedge pclk) disable iff (!rst_n)
        loopback_active |-> $past(!rate_gen2 && power_state == 2'b00 && det_lpbk_cmd));
endmodule

bind pipe_rdl_ctrl pipe_rdl_checker #(.CW(CW)) u_checker (
    .pclk            (pclk),
    .clk_fixed       (clk_fixed),
    .rst_n           (rst_n),
    .power_state     (power_state),
    .rate_gen2       (rate_gen2),
    .det_lpbk_cmd    (det_lpbk_cmd),
    .timeout_limit   (timeout_limit),
    .det_req         (det_req),
    .tx_elecidle     (tx_elecidle),
    .phy_status      (phy_status),
    .rx_status       (rx_status),
    .loopback_active (loopback_active)
);

// File: tb/pipe_rdl_ctrl_test.sv
module pipe_rdl_ctrl_test;
    localparam int DW = 16;
    localparam int CW = 16;

    logic          pclk = 0, clk_fixed = 0, rst_n = 0;
    logic [1:0]    power_state = 2'b10;
    logic          rate_gen2 = 0, det_lpbk_cmd = 0;
    logic [CW-1:0] timeout_limit = 16'd20;
    logic          det_req, det_done = 0, det_found = 0;
    logic [DW-1:0] tx_user_data = 16'h1111, rx_align_data = 16'hA5A5;
    logic          tx_user_elecidle = 0;
    logic [DW-1:0] tx_ser_data, rx_user_data;
    logic          tx_elecidle, phy_status, loopback_active;
    logic [2:0]    rx_status;

    int checks = 0, errors = 0;
    int req_rises = 0, req_hi = 0, pulses = 0, resp_cnt = 0;
    logic req_prev = 0;
    logic model_found = 0, model_silent = 0;

    always #4 clk_fixed = ~clk_fixed;
    always #2 pclk = ~pclk;

    pipe_rdl_ctrl #(.DW(DW), .CW(CW)) uut (
        .pclk(pclk), .clk_fixed(clk_fixed), .rst_n(rst_n),
        .power_state(power_state), .rate_gen2(rate_gen2),
        .det_lpbk_cmd(det_lpbk_cmd), .timeout_limit(timeout_limit),
        .det_req(det_req), .det_done(det_done), .det_found(det_found),
        .tx_user_data(tx_user_data), .tx_user_elecidle(tx_user_elecidle),
        .rx_align_data(rx_align_data), .tx_ser_data(tx_ser_data),
        .tx_elecidle(tx_elecidle), .rx_user_data(rx_user_data),
        .phy_status(phy_status), .rx_status(rx_status),
        .loopback_active(loopback_active)
    );

    // Analog front-end model: answers after 5 detect-clock cycles unless silent
    always @(posedge clk_fixed) begin
        if (!det_req) begin
            resp_cnt <= 0;
            det_done <= 1'b0;
        end else if (!model_silent) begin
            resp_cnt <= resp_cnt + 1;
            if (resp_cnt == 4) begin
                det_done  <= 1'b1;
                det_found <= model_found;
            end
        end
    end

    always @(negedge clk_fixed) begin
        if (det_req && !req_prev) begin
            req_rises = req_rises + 1;
            req_hi = 0;
        end
        if (det_req) req_hi = req_hi + 1;
        req_prev = det_req;
    end

    always @(negedge pclk) if (phy_status) pulses = pulses + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge pclk);
    endtask

    task automatic t_reset();
        tick(1);
        chk(phy_status == 0, "R1 phy_status", phy_status, 0);
        chk(rx_status == 0, "R1 rx_status", rx_status, 0);
        chk(det_req == 0, "R1 det_req", det_req, 0);
        chk(loopback_active == 0, "R1 loopback", loopback_active, 0);
        chk(tx_ser_data == tx_user_data, "R1 tx_ser_data", tx_ser_data, tx_user_data);
    endtask

    task automatic run_detect(input bit found, input bit silent, input logic [2:0] exp, input int limit);
        int  rises0, seen, idle_bad;
        rises0 = req_rises; seen = 0; idle_bad = 0;
        model_found = found; model_silent = silent; timeout_limit = CW'(limit);
        power_state = 2'b10; det_lpbk_cmd = 0;
        tick(2);
        det_lpbk_cmd = 1;
        for (int i = 0; i < 400 && !seen; i++) begin
            tick(1);
            if (!tx_elecidle) idle_bad++;
            if (phy_status) begin
                seen = 1;
                chk(rx_status == exp, "R4 rx_status at completion", rx_status, exp);
            end
        end
        chk(seen == 1, "R4 phy_status pulse seen", seen, 1);
        chk(idle_bad == 0, "R3 tx_elecidle held in P1", idle_bad, 0);
        tick(1);
        chk(phy_status == 0 && rx_status == 0, "R4 single-cycle pulse", {phy_status, rx_status}, 0);
        chk(req_rises == rises0 + 1, "R2 one detect request", req_rises - rises0, 1);
        if (silent)
            chk(req_hi == limit, "R5 timeout request length", req_hi, limit);
        det_lpbk_cmd = 0;
        tick(2);
    endtask

    task automatic t_hold_and_busy();
        int rises0, pulses0;
        // Hold high after a completed detect
        rises0 = req_rises; pulses0 = pulses;
        model_silent = 0; model_found = 1; timeout_limit = 16'd20;
        power_state = 2'b10;
        det_lpbk_cmd = 1;
        tick(300);
        chk(req_rises == rises0 + 1, "R6 held command no retrigger", req_rises - rises0, 1);
        chk(pulses == pulses0 + 1, "R6 one status pulse when held", pulses - pulses0, 1);
        det_lpbk_cmd = 0; tick(2);
        // Re-edge during a long detect
        rises0 = req_rises; pulses0 = pulses;
        model_silent = 1; timeout_limit = 16'd100;
        det_lpbk_cmd = 1; tick(30);
        det_lpbk_cmd = 0; tick(3);
        det_lpbk_cmd = 1; tick(400);
        chk(req_rises == rises0 + 1, "R6 edge while busy ignored", req_rises - rises0, 1);
        chk(pulses == pulses0 + 1, "R6 one pulse while busy", pulses - pulses0, 1);
        det_lpbk_cmd = 0; model_silent = 0; tick(2);
    endtask

    task automatic t_loopback();
        int rises0;
        rises0 = req_rises;
        power_state = 2'b00; rate_gen2 = 0; det_lpbk_cmd = 1;
        tick(1);
        chk(loopback_active == 1, "R7 loopback entered", loopback_active, 1);
        for (int k = 0; k < 3; k++) begin
            rx_align_data = 16'h1234 + DW'(k * 16'h1111);
            tx_user_data  = 16'hBEEF - DW'(k);
            #0.5;
            chk(tx_ser_data == rx_align_data, "R7 serializer takes rx data", tx_ser_data, rx_align_data);
            chk(rx_user_data == rx_align_data, "R9 rx passthrough in loopback", rx_user_data, rx_align_data);
            tick(1);
        end
        tick(50);
        chk(req_rises == rises0, "R7 no detect in P0", req_rises - rises0, 0);
        // exit by command drop
        det_lpbk_cmd = 0; tick(1);
        chk(tx_ser_data == tx_user_data && !loopback_active, "R10 exit on command drop", tx_ser_data, tx_user_data);
        chk(rx_user_data == rx_align_data, "R9 rx passthrough normal", rx_user_data, rx_align_data);
        // exit by power state
        det_lpbk_cmd = 1; tick(1);
        power_state = 2'b01; tick(1);
        chk(tx_ser_data == tx_user_data && !loopback_active, "R10 exit on leaving P0", tx_ser_data, tx_user_data);
        // exit by rate change
        power_state = 2'b00; tick(1);
        chk(loopback_active == 1, "R7 re-entry", loopback_active, 1);
        rate_gen2 = 1; tick(1);
        chk(tx_ser_data == tx_user_data && !loopback_active, "R10 exit on rate change", tx_ser_data, tx_user_data);
        det_lpbk_cmd = 0; tick(2);
    endtask

    task automatic t_gen2();
        rate_gen2 = 1; power_state = 2'b00; det_lpbk_cmd = 1;
        tx_user_data = 16'h5A5A; rx_align_data = 16'hC3C3;
        tick(5);
        chk(loopback_active == 0, "R8 no loopback at gen2", loopback_active, 0);
        chk(tx_ser_data == 16'h5A5A, "R8 user data kept at gen2", tx_ser_data, 16'h5A5A);
        det_lpbk_cmd = 0; rate_gen2 = 0; tick(2);
    endtask

    task automatic t_other_states();
        int rises0, pulses0, lb;
        for (int s = 0; s < 2; s++) begin
            rises0 = req_rises; pulses0 = pulses; lb = 0;
            power_state = (s == 0) ? 2'b01 : 2'b11;
            det_lpbk_cmd = 0; tick(2);
            det_lpbk_cmd = 1;
            for (int i = 0; i < 150; i++) begin
                tick(1);
                if (loopback_active) lb++;
            end
            chk(req_rises == rises0, "R11 no detect in P0s/P2", req_rises - rises0, 0);
            chk(pulses == pulses0, "R11 no status in P0s/P2", pulses - pulses0, 0);
            chk(lb == 0, "R11 no loopback in P0s/P2", lb, 0);
            det_lpbk_cmd = 0; tick(2);
        end
    endtask

    bit finished = 0;

    initial begin
        #20 rst_n = 1;
        t_reset();
        run_detect(1'b1, 1'b0, 3'b011, 20);
        run_detect(1'b0, 1'b0, 3'b000, 20);
        run_detect(1'b1, 1'b1, 3'b000, 12);
        t_hold_and_busy();
        t_loopback();
        t_gen2();
        t_other_states();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule